// File: doc/BRIEF.md
# Reference Divider with Selectable Post-Divide Tap

This block sits in the reference path of a dual phase-locked loop. It counts cycles of the buffered reference clock and produces a one-cycle strobe once every R cycles, where R is a 10-bit programmable ratio. A cascade of binary halving stages follows that strobe. A 3-bit code picks one of the resulting five strobe streams, and the picked stream drives the comparison input of the intermediate-frequency phase detector. The radio-frequency loop does not use the divider. It receives the reference clock directly on a separate output.

Changes to the ratio and to the tap code are never applied in the middle of a count. The counter takes a new ratio only when it reloads. The tap code is captured only on a base strobe. Because every tap strobe coincides with a base strobe, the selected output never produces a shortened interval. A two-flop reset synchronizer lets the reset assert asynchronously and release in step with the reference clock.

Top module: `refdiv_tap`

## Requirements
- R1: While `rst_n` is low, `if_cmp_pulse` is 0.
- R2: With tap code 0, `if_cmp_pulse` is a single-cycle high pulse that repeats every R reference cycles, for R from 4 to 1023.
- R3: Tap code k (binary 001 = 1 up to 100 = 4) gives pulses every R × 2^k reference cycles, and each pulse lasts one cycle.
- R4: Tap codes 5, 6 and 7 behave exactly like code 0, so the interval is R.
- R5: A ratio value of 0, 1, 2 or 3 is treated as 4.
- R6: The ratio is sampled only when the divide-by-R counter reaches terminal count. A count already running completes with the old ratio, and the following count uses the new one.
- R7: The tap code is captured on the cycle a base pulse is present. The pulse generated from that base pulse still uses the previous code, and later pulses use the new code.
- R8: `rf_ref_out` is the reference clock passed straight through: high while `clk_ref` is high and low while it is low.
- R9: After `rst_n` rises, the first `if_cmp_pulse` appears after the fourth rising edge of `clk_ref`. Two edges are spent on reset release, one on the counter's terminal flag and one on the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Buffered reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_r | input | 10 | Integer division ratio R (values below 4 are treated as 4) |
| tap_sel | input | 3 | Post-divide tap code (0 to 4; 5 to 7 act as 0) |
| if_cmp_pulse | output | 1 | One-cycle comparison strobe for the IF phase detector |
| rf_ref_out | output | 1 | Undivided reference for the RF phase detector |

## Verification
Every `if_cmp_pulse` appears one rising edge after the divide-by-R terminal flag, and that flag is set one edge after the counter reaches zero. A new ratio therefore first shows up in the output one full old-ratio interval after it is applied, and a new tap code takes effect only from the base pulse after the one that captured it. The bench runs a behavioural model that keeps a running count of base pulses and applies the ratio and tap code at those same sampling points. Outputs are compared on the falling edge after every rising edge. The interval checks skip the first three pulses after any change, so the counter reload and the code capture have both settled before an interval is measured. `rf_ref_out` has no register, so it is checked both in the high phase and in the low phase of the clock.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
  localparam int RATIO_W_DEF  = 10;
  localparam int SEL_W_DEF    = 3;
  localparam int NUM_TAPS_DEF = 5;
  localparam int R_MIN_DEF    = 4;

  // Codes outside the implemented tap range fall back to the undivided tap.
  function automatic logic [SEL_W_DEF-1:0] legalize_code(
    input logic [SEL_W_DEF-1:0] code,
    input int unsigned          n_taps
  );
    if (32'(code) >= n_taps) return '0;
    return code;
  endfunction
endpackage

// File: rtl/refdiv_rst_sync.sv
module refdiv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= shift_d;
  end

  assign srst_n = shift_q[STAGES-1];
endmodule

// File: rtl/refdiv_core.sv
module refdiv_core #(
  parameter int RATIO_W = refdiv_pkg::RATIO_W_DEF,
  parameter int R_MIN   = refdiv_pkg::R_MIN_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RATIO_W-1:0] ratio_in,
  output logic               base_pulse
);
  localparam int CNT_W = RATIO_W;
  localparam logic [CNT_W-1:0] MIN_V = CNT_W'(R_MIN);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d, eff_ratio;
  logic             tc_q, tc_d, at_term;

  always_comb begin
    eff_ratio = (ratio_in < MIN_V) ? MIN_V : ratio_in;
    at_term   = (cnt_q == '0);
    tc_d      = at_term;
    // ratio is taken only on reload, so a running count is never cut short
    cnt_d     = at_term ? (eff_ratio - ONE) : (cnt_q - ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tc_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tc_q  <= tc_d;
    end
  end

  assign base_pulse = tc_q;

  // R2: the base strobe is never wider than one cycle
  a_r2_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    tc_q |=> !tc_q);

  // R6: between reloads the count only steps down by one
  a_r6_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE));

  // R5: a reload never starts a period shorter than the minimum ratio
  a_r5_reload_min: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) |=> (cnt_q >= MIN_V - ONE));
endmodule

// File: rtl/refdiv_post_chain.sv
module refdiv_post_chain #(
  parameter int NUM_TAPS = refdiv_pkg::NUM_TAPS_DEF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                base_pulse,
  output logic [NUM_TAPS-1:0] taps
);
  assign taps[0] = base_pulse;

  for (genvar k = 1; k < NUM_TAPS; k++) begin : g_stage
    logic tog_q, tog_d;

    always_comb begin
      // toggle advances only on a strobe from the previous stage
      tog_d = taps[k-1] ? ~tog_q : tog_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tog_q <= 1'b0;
      else        tog_q <= tog_d;
    end

    // every second strobe of the previous stage passes through
    assign taps[k] = taps[k-1] & tog_q;

    // R3: a halved stream never fires on consecutive cycles
    a_r3_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
      taps[k] |=> !taps[k]);

    // R3: any tap strobe lines up with a base strobe
    a_r3_on_base: assert property (@(posedge clk) disable iff (!rst_n)
      taps[k] |-> base_pulse);
  end
endmodule

// File: rtl/refdiv_tap.sv
module refdiv_tap #(
  parameter int RATIO_W  = refdiv_pkg::RATIO_W_DEF,
  parameter int SEL_W    = refdiv_pkg::SEL_W_DEF,
  parameter int NUM_TAPS = refdiv_pkg::NUM_TAPS_DEF,
  parameter int R_MIN    = refdiv_pkg::R_MIN_DEF
) (
  input  logic               clk_ref,
  input  logic               rst_n,
  input  logic [RATIO_W-1:0] ratio_r,
  input  logic [SEL_W-1:0]   tap_sel,
  output logic               if_cmp_pulse,
  output logic               rf_ref_out
);
  logic                srst_n;
  logic                base_pulse;
  logic [NUM_TAPS-1:0] taps;
  logic [SEL_W-1:0]    sel_q, sel_d;
  logic                out_q, out_d;

  refdiv_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk    (clk_ref),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  refdiv_core #(.RATIO_W(RATIO_W), .R_MIN(R_MIN)) u_core (
    .clk        (clk_ref),
    .rst_n      (srst_n),
    .ratio_in   (ratio_r),
    .base_pulse (base_pulse)
  );

  refdiv_post_chain #(.NUM_TAPS(NUM_TAPS)) u_chain (
    .clk        (clk_ref),
    .rst_n      (srst_n),
    .base_pulse (base_pulse),
    .taps       (taps)
  );

  always_comb begin
    sel_d = base_pulse ? SEL_W'(refdiv_pkg::legalize_code(
              refdiv_pkg::SEL_W_DEF'(tap_sel), NUM_TAPS)) : sel_q;
    out_d = taps[sel_q];
  end

  always_ff @(posedge clk_ref or negedge srst_n) begin
    if (!srst_n) begin
      sel_q <= '0;
      out_q <= 1'b0;
    end else begin
      sel_q <= sel_d;
      out_q <= out_d;
    end
  end

  assign if_cmp_pulse = out_q;
  assign rf_ref_out   = clk_ref;

  // R7: the captured code moves only on a base strobe
  a_r7_sel_hold: assert property (@(posedge clk_ref) disable iff (!srst_n)
    !base_pulse |=> $stable(sel_q));

  // R4: the captured code is always a tap that exists
  a_r4_sel_legal: assert property (@(posedge clk_ref) disable iff (!srst_n)
    32'(sel_q) < NUM_TAPS);

  // R3: an output strobe always follows a base strobe by one cycle
  a_r3_out_follows_base: assert property (@(posedge clk_ref) disable iff (!srst_n)
    out_q |-> $past(base_pulse));
endmodule

// File: tb/refdiv_tap_tb.sv
module refdiv_tap_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 190000;

  logic       clk_ref = 1'b0;
  logic       rst_n;
  logic [9:0] ratio_r;
  logic [2:0] tap_sel;
  logic       if_cmp_pulse;
  logic       rf_ref_out;

  int    n_vec  = 0;
  int    n_fail = 0;
  int    cyc    = 0;
  bit    done   = 1'b0;
  string cur_req = "R1";

  refdiv_tap u_dut (
    .clk_ref      (clk_ref),
    .rst_n        (rst_n),
    .ratio_r      (ratio_r),
    .tap_sel      (tap_sel),
    .if_cmp_pulse (if_cmp_pulse),
    .rf_ref_out   (rf_ref_out)
  );

  always #(CLK_PERIOD/2) clk_ref = ~clk_ref;

  function automatic int clamp_r(input int r);
    return (r < 4) ? 4 : r;
  endfunction

  // behavioural reference: pulse counter and sampled settings
  bit m_rs1, m_rs2, m_tc, m_if;
  int m_cnt, m_sel, m_pc;

  always @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      m_rs1 = 0; m_rs2 = 0; m_tc = 0; m_if = 0;
      m_cnt = 0; m_sel = 0; m_pc = 0;
    end else begin
      cyc++;
      if (m_rs2) begin
        bit nif, ntc;
        nif = m_tc && (((m_pc + 1) % (1 << m_sel)) == 0);
        if (m_tc) begin
          m_pc++;
          m_sel = (int'(tap_sel) > 4) ? 0 : int'(tap_sel);
        end
        ntc   = (m_cnt == 0);
        m_cnt = ntc ? clamp_r(int'(ratio_r)) - 1 : m_cnt - 1;
        m_if  = nif;
        m_tc  = ntc;
      end
      m_rs2 = m_rs1;
      m_rs1 = 1;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // per-cycle comparison in the low phase
  always @(negedge clk_ref) begin
    if (!done) begin
      check(cur_req, "if_cmp_pulse vs model", int'(if_cmp_pulse), int'(m_if));
      check("R8", "rf_ref_out low phase", int'(rf_ref_out), 0);
      if (!rst_n) check("R1", "if_cmp_pulse in reset", int'(if_cmp_pulse), 0);
    end
  end

  always @(posedge clk_ref) begin
    #(CLK_PERIOD/4);
    if (!done) check("R8", "rf_ref_out high phase", int'(rf_ref_out), 1);
  end

  always @(posedge clk_ref) begin
    if (cyc > WD_LIMIT && !done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL %s watchdog: actual %0d cycles expected below %0d", cur_req, cyc, WD_LIMIT);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  task automatic wait_pulse(output int at);
    at = -1;
    while (!done) begin
      @(negedge clk_ref);
      if (if_cmp_pulse) begin at = cyc; return; end
    end
  endtask

  task automatic measure(input int r, input int s, input string req);
    int t_prev, t_now, exp_iv;
    @(negedge clk_ref);
    ratio_r = 10'(r);
    tap_sel = 3'(s);
    cur_req = req;
    exp_iv  = clamp_r(r) << ((s > 4) ? 0 : s);
    for (int i = 0; i < 4; i++) wait_pulse(t_prev);
    wait_pulse(t_now);
    check(req, $sformatf("interval R=%0d code=%0d", r, s), t_now - t_prev, exp_iv);
  endtask

  initial begin
    int t0, t1, t2;
    rst_n   = 1'b0;
    ratio_r = 10'd4;
    tap_sel = 3'd0;
    repeat (5) @(negedge clk_ref);

    // R9: first output strobe timing after release
    cur_req = "R9";
    rst_n   = 1'b1;
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk_ref);
      check("R9", $sformatf("first strobe edge %0d", i), int'(if_cmp_pulse), (i == 4) ? 1 : 0);
    end

    measure(4, 0, "R2");
    measure(7, 0, "R2");
    measure(100, 0, "R2");
    for (int k = 1; k <= 4; k++) begin
      measure(4, k, "R3");
      measure(7, k, "R3");
      measure(100, k, "R3");
    end
    measure(1023, 0, "R2");
    measure(1023, 2, "R3");
    measure(5, 5, "R4");
    measure(5, 6, "R4");
    measure(13, 7, "R4");
    measure(2, 1, "R5");
    measure(0, 0, "R5");
    measure(3, 2, "R5");
    measure(1, 0, "R5");

    // R6: ratio changed mid-count
    measure(50, 0, "R6");
    cur_req = "R6";
    wait_pulse(t0);
    repeat (10) @(negedge clk_ref);
    ratio_r = 10'd20;
    wait_pulse(t1);
    wait_pulse(t2);
    check("R6", "interval finishing old ratio", t1 - t0, 50);
    check("R6", "interval with new ratio", t2 - t1, 20);

    // R7: code change applies after the capturing strobe
    measure(10, 0, "R7");
    cur_req = "R7";
    wait_pulse(t0);
    tap_sel = 3'd1;
    wait_pulse(t1);
    check("R7", "strobe from capturing base pulse", t1 - t0, 10);
    measure(10, 1, "R7");

    repeat (4) @(negedge clk_ref);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule